// File: doc/BRIEF.md
# Four-Channel Byte Transfer Engine

This block moves single bytes between peripherals and a byte-wide memory on behalf of a processor. Each of four peripherals raises its own request line. When an enabled channel requests, the engine raises a hold request toward the processor. It then picks one channel, by fixed or by rotating priority, and runs a four-cycle transfer on it. Depending on the channel's transfer type, the transfer either reads memory and hands the byte to the peripheral, or takes a byte from the peripheral and writes it to memory. Afterwards the channel's address steps up by one and its count steps down by one.

Software programs the engine through a small byte-wide register port. Each channel has a 16-bit start address and a 14-bit count that carries the transfer type in its upper bits. Both are loaded low byte first through one shared byte-select toggle. A mode byte carries the channel enables and the option flags. When a channel reaches terminal count, it pulses a done line to its peripheral and latches a completion flag. Software collects these flags by reading status, and the read clears them. An optional mode stops a channel once it reaches terminal count.

Top module: `bdma_top`

## Requirements
- R1: After reset, hold_req, dack, done, mem_rd, mem_wr and tc are low, all channel enables, option flags and completion flags are clear, the rotating pointer is 0 and the byte toggle selects the low byte. A status read returns 0, and no request is granted.
- R2: Register offset 2*c is the address of channel c and offset 2*c+1 is its count, for c = 0..3. Each register is loaded by two writes, low byte and then high byte. One toggle shared by all eight registers picks the byte and flips on every write to offsets 0..7. A write to offset 8 (mode) returns the toggle to the low byte.
- R3: Mode byte: bits 3:0 enable channels 3..0, bit 4 selects rotating priority and bit 6 selects stop-at-terminal-count. Bits 5 and 7 are accepted and have no effect on transfers.
- R4: The count high byte holds count bits 13:8 in its bits 5:0 and the transfer type in bits 7:6: 0 verify, 1 write (peripheral to memory), 2 read (memory to peripheral), 3 invalid. A programmed count N moves N+1 bytes before terminal count. Later transfers continue with the count wrapped past zero.
- R5: A channel is eligible when its enable bit is set and its drq line is high. hold_req is high in any cycle in which some channel is eligible or a transfer is in progress. A grant begins in the cycle after an idle cycle with an eligible channel.
- R6: With fixed priority, the eligible channel with the lowest number is granted.
- R7: With rotating priority, the search starts at a pointer, and after each grant the pointer becomes the granted channel plus one, modulo 4. Fixed-priority grants leave the pointer unchanged.
- R8: A transfer takes four cycles: arbitration, an address cycle, a move cycle and an update cycle. mem_addr carries the channel address in the address and move cycles. Read type raises mem_rd in the address cycle. In the move cycle the one-hot dack of the channel is high. Read type drives per_wdata from mem_rdata, and write type raises mem_wr with mem_wdata equal to per_rdata.
- R9: Verify and invalid types raise neither mem_rd nor mem_wr but still update address and count.
- R10: In the update cycle of the transfer that reaches terminal count, the channel's done bit pulses for one cycle and its completion flag is set. With stop-at-terminal-count the channel's enable is also cleared. tc shows from the next cycle whether the last serviced transfer was terminal.
- R11: A status read (reg_rd at offset 8) returns the completion flags in bits 3:0 and zeros in bits 7:4, and clears all flags. A flag set in the same cycle survives.
- R12: Each transfer increments the channel address by one, wrapping at 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Status byte during a status read, else 0 |
| drq | input | 4 | Per-channel peripheral request |
| dack | output | 4 | Per-channel acknowledge, high in the move cycle |
| done | output | 4 | Per-channel terminal-count pulse |
| per_rdata | input | 8 | Byte from the peripheral (write type) |
| per_wdata | output | 8 | Byte to the peripheral (read type) |
| hold_req | output | 1 | Bus hold request to the processor |
| tc | output | 1 | Last serviced transfer reached terminal count |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe; data expected one cycle later |
| mem_rdata | input | 8 | Memory read byte |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |

## Verification
The bench builds the engine with its default parameters: four channels, 16-bit addresses and 14-bit counts. With four channels, every one of the 16 enable patterns can be swept against every one of the 15 non-empty request patterns, and each grant and hold level is compared with a lowest-set-bit calculation. The rotating mode is driven through a computed stream of request patterns against a modeled pointer. Short counts bring terminal count, stop-at-terminal-count, count wrap, address carry across a byte boundary and the shared byte toggle within a few transfers.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

  typedef enum logic [1:0] {
    XT_VERIFY  = 2'd0,
    XT_WRITE   = 2'd1,
    XT_READ    = 2'd2,
    XT_INVALID = 2'd3
  } xfer_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_MOVE = 2'd2,
    PH_UPD  = 2'd3
  } phase_t;

  localparam int MB_ROTATE  = 4;
  localparam int MB_TC_STOP = 6;

endpackage

// File: rtl/bdma_chan.sv
module bdma_chan
  import bdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr_lo,
  input  logic              ld_addr_hi,
  input  logic              ld_cnt_lo,
  input  logic              ld_cnt_hi,
  input  logic [7:0]        wbyte,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output xfer_t             xtype,
  output logic              last
);

  localparam int AH_W = ADDR_W - 8;
  localparam int CH_W = CNT_W - 8;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  xfer_t             type_q, type_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    type_d = type_q;
    if (ld_addr_lo)      addr_d[7:0]        = wbyte;
    else if (ld_addr_hi) addr_d[ADDR_W-1:8] = wbyte[AH_W-1:0];
    else if (step)       addr_d             = addr_q + 1'b1;
    if (ld_cnt_lo) begin
      cnt_d[7:0] = wbyte;
    end else if (ld_cnt_hi) begin
      cnt_d[CNT_W-1:8] = wbyte[CH_W-1:0];
      type_d           = xfer_t'(wbyte[7:6]);
    end else if (step) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      type_q <= XT_VERIFY;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      type_q <= type_d;
    end
  end

  assign addr  = addr_q;
  assign cnt   = cnt_q;
  assign xtype = type_q;
  assign last  = (cnt_q == '0);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_addr_lo && !ld_addr_hi) |=> (addr_q == $past(addr_q) + 1'b1)); // R12
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_cnt_lo && !ld_cnt_hi) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/bdma_arb.sv
module bdma_arb #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic [IW-1:0]  start,
  output logic           any,
  output logic [IW-1:0]  idx
);

  always_comb begin
    logic [IW:0] pos;
    any = 1'b0;
    idx = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (rotate) begin
        pos = {1'b0, start} + (IW+1)'(k);
        if (pos >= (IW+1)'(NCH)) pos = pos - (IW+1)'(NCH);
      end else begin
        pos = (IW+1)'(k);
      end
      if (req[pos[IW-1:0]]) begin
        any = 1'b1;
        idx = pos[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/bdma_top.sv
module bdma_top
  import bdma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NCH-1:0]    drq,
  output logic [NCH-1:0]    dack,
  output logic [NCH-1:0]    done,
  input  logic [7:0]        per_rdata,
  output logic [7:0]        per_wdata,
  output logic              hold_req,
  output logic              tc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata
);

  localparam int IW       = $clog2(NCH);
  localparam int MODE_OFS = 2 * NCH;

  // reset: asynchronous assertion, synchronous release
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  phase_t          phase_q, phase_d;
  logic [IW-1:0]   sel_q, sel_d, ptr_q, ptr_d;
  logic [NCH-1:0]  en_q, en_d, cmpl_q, cmpl_d;
  logic            rot_q, rot_d, stop_q, stop_d, hi_q, hi_d, tc_q, tc_d;

  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [CNT_W-1:0]  ch_cnt  [NCH];
  xfer_t             ch_type [NCH];
  logic [NCH-1:0]    ch_last, step_v, elig;
  logic              arb_any, mode_wr, stat_rd, ld_wr, in_upd;
  logic [IW-1:0]     arb_idx;
  xfer_t             cur_type;

  assign mode_wr = reg_wr && (reg_addr == REG_AW'(MODE_OFS));
  assign stat_rd = reg_rd && (reg_addr == REG_AW'(MODE_OFS));
  assign ld_wr   = reg_wr && (reg_addr < REG_AW'(MODE_OFS));
  assign in_upd  = (phase_q == PH_UPD);
  assign elig    = en_q & drq;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wa, wc;
    assign wa        = reg_wr && (reg_addr == REG_AW'(2 * i));
    assign wc        = reg_wr && (reg_addr == REG_AW'(2 * i + 1));
    assign step_v[i] = in_upd && (sel_q == IW'(i));
    bdma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chan_i (
      .clk(clk), .rst_n(rs_n),
      .ld_addr_lo(wa && !hi_q), .ld_addr_hi(wa && hi_q),
      .ld_cnt_lo(wc && !hi_q),  .ld_cnt_hi(wc && hi_q),
      .wbyte(reg_wdata), .step(step_v[i]),
      .addr(ch_addr[i]), .cnt(ch_cnt[i]), .xtype(ch_type[i]), .last(ch_last[i])
    );
  end

  bdma_arb #(.NCH(NCH), .IW(IW)) arb_i (
    .req(elig), .rotate(rot_q), .start(ptr_q), .any(arb_any), .idx(arb_idx)
  );

  assign cur_type = ch_type[sel_q];
  assign done     = step_v & ch_last;

  // next state
  always_comb begin
    phase_d = phase_q;
    sel_d   = sel_q;
    ptr_d   = ptr_q;
    en_d    = en_q;
    rot_d   = rot_q;
    stop_d  = stop_q;
    hi_d    = hi_q;
    tc_d    = tc_q;
    cmpl_d  = (stat_rd ? '0 : cmpl_q) | done;
    case (phase_q)
      PH_IDLE: if (arb_any) begin
        phase_d = PH_ADDR;
        sel_d   = arb_idx;
        if (rot_q) ptr_d = arb_idx + 1'b1;
      end
      PH_ADDR: phase_d = PH_MOVE;
      PH_MOVE: phase_d = PH_UPD;
      default: begin
        phase_d = PH_IDLE;
        tc_d    = ch_last[sel_q];
        if (stop_q && ch_last[sel_q]) en_d[sel_q] = 1'b0;
      end
    endcase
    if (ld_wr) hi_d = ~hi_q;
    if (mode_wr) begin
      hi_d   = 1'b0;
      en_d   = reg_wdata[NCH-1:0];
      rot_d  = reg_wdata[MB_ROTATE];
      stop_d = reg_wdata[MB_TC_STOP];
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      phase_q <= PH_IDLE;
      sel_q   <= '0;
      ptr_q   <= '0;
      en_q    <= '0;
      rot_q   <= 1'b0;
      stop_q  <= 1'b0;
      hi_q    <= 1'b0;
      tc_q    <= 1'b0;
      cmpl_q  <= '0;
    end else begin
      phase_q <= phase_d;
      sel_q   <= sel_d;
      ptr_q   <= ptr_d;
      en_q    <= en_d;
      rot_q   <= rot_d;
      stop_q  <= stop_d;
      hi_q    <= hi_d;
      tc_q    <= tc_d;
      cmpl_q  <= cmpl_d;
    end
  end

  // outputs
  assign hold_req  = (|elig) || (phase_q != PH_IDLE);
  assign tc        = tc_q;
  assign reg_rdata = stat_rd ? {{(8-NCH){1'b0}}, cmpl_q} : 8'h00;
  assign mem_addr  = (phase_q == PH_ADDR || phase_q == PH_MOVE) ? ch_addr[sel_q] : '0;
  assign mem_rd    = (phase_q == PH_ADDR) && (cur_type == XT_READ);
  assign mem_wr    = (phase_q == PH_MOVE) && (cur_type == XT_WRITE);
  assign mem_wdata = mem_wr ? per_rdata : 8'h00;
  assign dack      = (phase_q == PH_MOVE) ? (NCH'(1) << sel_q) : '0;
  assign per_wdata = ((phase_q == PH_MOVE) && (cur_type == XT_READ)) ? mem_rdata : 8'h00;

  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rs_n)
    $onehot0(dack)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rs_n)
    !(mem_rd && mem_wr)); // R8
  AST_GRANT_START: assert property (@(posedge clk) disable iff (!rs_n)
    (phase_q == PH_IDLE && (|elig)) |=> (phase_q == PH_ADDR)); // R5
  AST_MOVE_TO_UPD: assert property (@(posedge clk) disable iff (!rs_n)
    (phase_q == PH_MOVE) |=> (phase_q == PH_UPD)); // R8
  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rs_n)
    (phase_q == PH_IDLE && !rot_q && (|elig))
      |=> (($past(elig) & ((NCH'(1) << sel_q) - NCH'(1))) == '0)); // R6
  AST_VERIFY_QUIET: assert property (@(posedge clk) disable iff (!rs_n)
    (cur_type == XT_VERIFY || cur_type == XT_INVALID) |-> !(mem_rd || mem_wr)); // R9
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rs_n)
    (|done) |=> ((cmpl_q & $past(done)) == $past(done))); // R10
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rs_n)
    (stat_rd && !(|done)) |=> (cmpl_q == '0)); // R11

endmodule

// File: tb/bdma_top_tb_top.sv
module bdma_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [3:0] drq = '0, dack, done;
  logic [7:0] per_rdata = '0, per_wdata, mem_rdata = '0, mem_wdata;
  logic       hold_req, tc, mem_rd, mem_wr;
  logic [15:0] mem_addr;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  bdma_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .drq(drq), .dack(dack), .done(done), .per_rdata(per_rdata),
    .per_wdata(per_wdata), .hold_req(hold_req), .tc(tc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  // captured results of one transfer attempt
  int          cap_ch, cap_lat;
  logic        cap_hold, cap_rd, cap_wr, cap_tc;
  logic [15:0] cap_addr, cap_maddr;
  logic [7:0]  cap_wdata, cap_pw;
  logic [3:0]  cap_done;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; drq = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = off;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input logic [13:0] n, input logic [1:0] ty);
    wr(4'(2*ch), a[7:0]);
    wr(4'(2*ch), a[15:8]);
    wr(4'(2*ch+1), n[7:0]);
    wr(4'(2*ch+1), {ty, n[13:8]});
  endtask

  task automatic run_one(input logic [3:0] req);
    drq = req;
    #1 cap_hold = hold_req;
    cap_ch = -1; cap_lat = 0; cap_rd = 1'b0; cap_addr = '0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (dack != 4'd0) begin
        for (int c = 0; c < 4; c++) if (dack[c]) cap_ch = c;
        cap_lat = k; cap_wr = mem_wr; cap_wdata = mem_wdata;
        cap_pw = per_wdata; cap_maddr = mem_addr;
        drq = '0;
        @(negedge clk);
        cap_done = done;
        @(negedge clk);
        cap_tc = tc;
        break;
      end else begin
        cap_addr = mem_addr; cap_rd = mem_rd;
        if (mem_rd) mem_rdata = mem_addr[7:0] ^ 8'h5A;
      end
    end
    drq = '0;
  endtask

  function automatic int lowest(input logic [3:0] v);
    for (int c = 0; c < 4; c++) if (v[c]) return c;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] st;
    int ptr, exp_ch;
    logic [3:0] rq;

    @(negedge clk);
    do_reset();

    // R1 reset state
    chk(!hold_req && dack == 0 && done == 0, "R1 idle outputs", {hold_req, dack}, 0);
    chk(!mem_rd && !mem_wr && !tc, "R1 strobes and tc", {mem_rd, mem_wr, tc}, 0);
    rd(4'd8, st);
    chk(st == 8'h00, "R1 status after reset", st, 0);
    run_one(4'hF);
    chk(cap_ch == -1 && !cap_hold, "R1 no enables after reset", cap_ch, -1);

    // R6 / R5 fixed-priority sweep over all enable and request patterns
    for (int c = 0; c < 4; c++) prog(c, 16'h0100 * c, 14'h3FFF, 2'd0);
    for (int en = 0; en < 16; en++) begin
      wr(4'd8, 8'(en));
      for (int r = 1; r < 16; r++) begin
        run_one(4'(r));
        exp_ch = lowest(4'(en) & 4'(r));
        chk(cap_ch == exp_ch, "R6 fixed grant", cap_ch, exp_ch);
        chk(cap_hold == (exp_ch != -1), "R5 hold level", cap_hold, exp_ch != -1);
      end
    end

    // R3 bits 5 and 7 have no effect
    wr(4'd8, 8'hA3);
    run_one(4'h3);
    chk(cap_ch == 0 && cap_lat == 2, "R3 ignored mode bits", cap_lat, 2);

    // R7 rotating priority
    do_reset();
    for (int c = 0; c < 4; c++) prog(c, 16'h0100 * c, 14'h3FFF, 2'd0);
    wr(4'd8, 8'h1F);
    ptr = 0;
    for (int i = 0; i < 40; i++) begin
      rq = 4'(((i * 5 + 3) % 15) + 1);
      exp_ch = -1;
      for (int k = 0; k < 4; k++)
        if (exp_ch == -1 && rq[(ptr + k) % 4]) exp_ch = (ptr + k) % 4;
      run_one(rq);
      chk(cap_ch == exp_ch, "R7 rotating grant", cap_ch, exp_ch);
      ptr = (exp_ch + 1) % 4;
    end

    // R8 R12 R4 R10 read-type transfers with address carry
    do_reset();
    wr(4'd8, 8'h02);
    prog(1, 16'h12FE, 14'd2, 2'd2);
    for (int j = 0; j < 4; j++) begin
      run_one(4'h2);
      chk(cap_ch == 1 && cap_lat == 2, "R8 grant timing", cap_lat, 2);
      chk(cap_addr == 16'h12FE + 16'(j), "R12 address step", cap_addr, 16'h12FE + j);
      chk(cap_rd && !cap_wr, "R8 read strobe", {cap_rd, cap_wr}, 2);
      chk(cap_pw == ((cap_addr[7:0]) ^ 8'h5A), "R8 read data to peripheral", cap_pw, cap_addr[7:0] ^ 8'h5A);
      chk(cap_done == ((j == 2) ? 4'h2 : 4'h0), "R4 count plus one bytes", cap_done, (j == 2) ? 2 : 0);
      chk(cap_tc == (j == 2), "R10 tc output", cap_tc, j == 2);
      if (j == 2) begin
        rd(4'd8, st);
        chk(st == 8'h02, "R11 status bits", st, 2);
        rd(4'd8, st);
        chk(st == 8'h00, "R11 cleared by read", st, 0);
      end
    end

    // R10 R8 write type with stop at terminal count
    per_rdata = 8'hC3;
    wr(4'd8, 8'h44);
    prog(2, 16'h0400, 14'd1, 2'd1);
    for (int j = 0; j < 2; j++) begin
      run_one(4'h4);
      chk(cap_ch == 2 && cap_wr && !cap_rd, "R8 write strobe", {cap_wr, cap_rd}, 2);
      chk(cap_wdata == 8'hC3 && cap_maddr == 16'h0400 + 16'(j), "R8 write data and address", cap_maddr, 16'h0400 + j);
      chk(cap_done == ((j == 1) ? 4'h4 : 4'h0), "R10 done pulse", cap_done, (j == 1) ? 4 : 0);
    end
    run_one(4'h4);
    chk(cap_ch == -1, "R10 stop disables channel", cap_ch, -1);
    rd(4'd8, st);
    chk(st == 8'h04, "R11 status after stop", st, 4);

    // R9 verify and invalid types
    wr(4'd8, 8'h09);
    prog(0, 16'h2000, 14'h3FFF, 2'd0);
    prog(3, 16'h3000, 14'd0, 2'd3);
    for (int j = 0; j < 2; j++) begin
      run_one(4'h1);
      chk(!cap_rd && !cap_wr && cap_addr == 16'h2000 + 16'(j), "R9 verify quiet and stepping", cap_addr, 16'h2000 + j);
    end
    run_one(4'h8);
    chk(cap_ch == 3 && !cap_rd && !cap_wr, "R9 invalid quiet", {cap_rd, cap_wr}, 0);
    chk(cap_done == 4'h8 && cap_tc, "R9 invalid reaches terminal", cap_done, 8);

    // R2 shared byte toggle and mode-write reset
    wr(4'd8, 8'h02);
    prog(1, 16'h0000, 14'h3FFF, 2'd0);
    wr(4'd0, 8'h11);
    wr(4'd2, 8'h22);
    run_one(4'h2);
    chk(cap_ch == 1 && cap_addr == 16'h2200, "R2 toggle shared across registers", cap_addr, 16'h2200);
    wr(4'd6, 8'h77);
    wr(4'd8, 8'h08);
    wr(4'd6, 8'h34);
    wr(4'd6, 8'h56);
    run_one(4'h8);
    chk(cap_ch == 3 && cap_addr == 16'h5634, "R2 mode write resets toggle", cap_addr, 16'h5634);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule